// File: doc/BRIEF.md
# Software Store Unlock Sequence Detector

This block watches the accesses on the 13-bit address bus of an 8K x 8 memory and detects a key: six reads in a fixed order, with no other access between them. When the sixth read of the key completes, it raises a store request for exactly one clock. A separate store engine acts on that request. The engine's busy signal then keeps the detector quiet until the store is finished. The block does not execute the store and does not touch the data path.

An access is counted once, on the clock where the chip-enable strobe is first seen inactive after being active. The address and the read/write flag are taken from the last cycle in which the strobe was active. Any write breaks a partially entered key, and so does a read of an address other than the expected one. A new read of the first key address restarts the key at step one.

Top module: `sw_store_seq_det`

## Requirements
- R1: After reset, `seq_state` is 0 and `store_req` is 0.
- R2: `seq_state` gives the number of key reads matched so far (0 to 5). The key addresses in order are 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F. `store_req` is 1 in the cycle right after a read of 0x0F0F completes in state 5.
- R3: An access completes on the first clock at which `acc_en` is sampled 0 after being 1. A strobe held active for several cycles counts as one access, and the state does not change while the strobe is active.
- R4: A completed read of any address other than the expected one, in states 1 to 5, returns `seq_state` to 0 unless R6 applies. No store request results.
- R5: A completed write (`acc_wr` = 1) returns `seq_state` to 0 from any state below 6, even when it targets the expected address.
- R6: A completed read of 0x0000 that breaks the key leaves `seq_state` at 1.
- R7: `store_req` is high for exactly one cycle. In that same cycle `seq_state` becomes 6, the locked code.
- R8: In state 6, completed accesses are ignored. The block stays in state 6 until `busy` has been seen high and then low. It returns to state 0 on the first clock at which `busy` is sampled low after that.
- R9: While `busy` is high and the block is not locked, `seq_state` is held at 0 and completed accesses are ignored.
- R10: The address and direction of an access are those present in the last cycle the strobe was active. Changes on the bus after the strobe drops do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Chip-enable access strobe, active high |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 13 | Access address |
| busy | input | 1 | Store engine busy |
| store_req | output | 1 | One-clock store request |
| seq_state | output | 3 | 0-5 key reads matched, 6 locked |

## Verification
The strobe is registered once. The completion is seen on the first clock edge that samples `acc_en` low, and the state and request registers load on that same edge. Every access task therefore drops the strobe on a falling edge and samples the outputs on the next falling edge. `store_req` is checked there and again one falling edge later, to prove it lasts one cycle. The release of the lock is sampled one falling edge after `busy` is driven low. A check inside a held strobe confirms that nothing moves before the strobe drops.

// File: rtl/svd_pkg.sv
package svd_pkg;
    localparam int ADDR_W  = 13;
    localparam int KEY_LEN = 6;
    localparam int STEP_W  = $clog2(KEY_LEN + 1);
    localparam logic [STEP_W-1:0] ST_LOCKED = STEP_W'(KEY_LEN);
    localparam logic [STEP_W-1:0] ST_LAST   = STEP_W'(KEY_LEN - 1);

    // Key address for a given position of the unlock order
    function automatic logic [ADDR_W-1:0] key_addr(input int idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            0:       a = 13'h0000;
            1:       a = 13'h1555;
            2:       a = 13'h0AAA;
            3:       a = 13'h1FFF;
            4:       a = 13'h10F0;
            default: a = 13'h0F0F;
        endcase
        return a;
    endfunction

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } access_t;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } tap_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              locked;
        logic              busy_seen;
        logic              req;
    } seq_t;
endpackage

// File: rtl/svd_access_tap.sv
module svd_access_tap
    import svd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output access_t           evt
);
    tap_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        t_d.en = acc_en;
        if (acc_en) begin
            t_d.wr   = acc_wr;
            t_d.addr = acc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        evt.valid = t_q.en & ~acc_en;
        evt.wr    = t_q.wr;
        evt.addr  = t_q.addr;
    end

    // R3
    one_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.valid |=> !evt.valid);
endmodule

// File: rtl/svd_key_match.sv
module svd_key_match
    import svd_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_step,
    output logic              hit_first
);
    logic [KEY_LEN-1:0] hit_vec;

    for (genvar i = 0; i < KEY_LEN; i++) begin : g_cmp
        assign hit_vec[i] = (addr == key_addr(i));
    end

    always_comb begin
        hit_step = 1'b0;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (step == STEP_W'(i)) hit_step = hit_vec[i];
        end
        hit_first = hit_vec[0];
    end
endmodule

// File: rtl/svd_seq_fsm.sv
module svd_seq_fsm
    import svd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  access_t           evt,
    input  logic              hit_step,
    input  logic              hit_first,
    input  logic              busy,
    output logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] state_code,
    output logic              req
);
    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (s_q.locked) begin
            s_d.step = '0;
            if (busy) begin
                s_d.busy_seen = 1'b1;
            end else if (s_q.busy_seen) begin
                s_d.locked    = 1'b0;
                s_d.busy_seen = 1'b0;
            end
        end else if (busy) begin
            s_d.step = '0;
        end else if (evt.valid) begin
            if (!evt.wr && hit_step) begin
                if (s_q.step == ST_LAST) begin
                    s_d.req       = 1'b1;
                    s_d.locked    = 1'b1;
                    s_d.busy_seen = 1'b0;
                    s_d.step      = '0;
                end else begin
                    s_d.step = s_q.step + STEP_W'(1);
                end
            end else if (!evt.wr && hit_first) begin
                s_d.step = STEP_W'(1);
            end else begin
                s_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign step       = s_q.step;
    assign state_code = s_q.locked ? ST_LOCKED : s_q.step;
    assign req        = s_q.req;

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(step) && step != '0) |-> (step == $past(step) + STEP_W'(1) || step == STEP_W'(1)));
    // R9
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_code == '0 || state_code == ST_LOCKED));
endmodule

// File: rtl/sw_store_seq_det.sv
module sw_store_seq_det
    import svd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              busy,
    output logic              store_req,
    output logic [STEP_W-1:0] seq_state
);
    access_t           evt;
    logic              hit_step;
    logic              hit_first;
    logic [STEP_W-1:0] step;

    svd_access_tap u_tap (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .evt      (evt)
    );

    svd_key_match u_match (
        .step      (step),
        .addr      (evt.addr),
        .hit_step  (hit_step),
        .hit_first (hit_first)
    );

    svd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .hit_step   (hit_step),
        .hit_first  (hit_first),
        .busy       (busy),
        .step       (step),
        .state_code (seq_state),
        .req        (store_req)
    );

    // R2
    req_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> $past(seq_state) == ST_LAST);
    // R7
    req_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> seq_state == ST_LOCKED);
    // R5
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.valid && evt.wr && !busy && seq_state != ST_LOCKED) |=> seq_state == '0);
    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_LOCKED && busy) |=> seq_state == ST_LOCKED);
endmodule

// File: tb/sw_store_seq_det_test.sv
`timescale 1ns/1ps
module sw_store_seq_det_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic        store_req;
    logic [2:0]  seq_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [12:0] K0 = 13'h0000, K1 = 13'h1555, K2 = 13'h0AAA,
                            K3 = 13'h1FFF, K4 = 13'h10F0, K5 = 13'h0F0F;

    always #10 clk = ~clk;

    sw_store_seq_det uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .busy(busy), .store_req(store_req), .seq_state(seq_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [12:0] a, input int hold,
                          input logic [12:0] after_a);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a;
        repeat (hold) @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_addr = after_a;
        @(negedge clk);
    endtask

    task automatic rd(input logic [12:0] a);
        access(1'b0, a, 1, 13'h0123);
    endtask

    task automatic release_lock();
        @(negedge clk); busy = 1'b1;
        @(negedge clk);
        chk("R8 busy high keeps lock", seq_state, 6);
        rd(K0);
        chk("R8 read under busy ignored", seq_state, 6);
        busy = 1'b0;
        @(negedge clk);
        chk("R8 unlock after busy low", seq_state, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset state", seq_state, 0);
        chk("R1 reset req", store_req, 0);
    endtask

    task automatic t_full_key();
        rd(K0); chk("R2 step1", seq_state, 1);
        rd(K1); chk("R2 step2", seq_state, 2);
        rd(K2); chk("R2 step3", seq_state, 3);
        rd(K3); chk("R2 step4", seq_state, 4);
        rd(K4); chk("R2 step5", seq_state, 5);
        chk("R2 no early req", store_req, 0);
        rd(K5);
        chk("R2 req after sixth read", store_req, 1);
        chk("R7 locked with req", seq_state, 6);
        @(negedge clk);
        chk("R7 req one cycle", store_req, 0);
        rd(K0);
        chk("R8 read while locked ignored", seq_state, 6);
        access(1'b1, K0, 1, 13'h0);
        chk("R8 write while locked ignored", seq_state, 6);
        release_lock();
    endtask

    task automatic t_long_strobe();
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = K0;
        repeat (4) @(negedge clk);
        chk("R3 no change during strobe", seq_state, 0);
        acc_en = 1'b0;
        @(negedge clk);
        chk("R3 held strobe counts once", seq_state, 1);
        @(negedge clk);
        chk("R3 no second count", seq_state, 1);
        rd(K2);
        chk("R4 wrong address at step1", seq_state, 0);
    endtask

    task automatic t_wrong_addr();
        rd(K0); rd(K1); rd(K2);
        chk("R4 reached step3", seq_state, 3);
        rd(13'h1FFE);
        chk("R4 wrong address aborts", seq_state, 0);
        chk("R4 no req on abort", store_req, 0);
    endtask

    task automatic t_write_abort();
        rd(K0); rd(K1);
        access(1'b1, K2, 1, 13'h0);
        chk("R5 write to expected addr aborts", seq_state, 0);
        rd(K0);
        access(1'b1, K0, 1, 13'h0);
        chk("R5 write of 0x0000 aborts to 0", seq_state, 0);
    endtask

    task automatic t_restart();
        rd(K0); rd(K1); rd(K2); rd(K3);
        rd(K0);
        chk("R6 abort by 0x0000 gives step1", seq_state, 1);
        rd(K1); rd(K2); rd(K3); rd(K4);
        chk("R6 continued to step5", seq_state, 5);
        rd(K5);
        chk("R6 store after restart", store_req, 1);
        release_lock();
    endtask

    task automatic t_busy_idle();
        rd(K0); rd(K1);
        @(negedge clk); busy = 1'b1;
        @(negedge clk);
        chk("R9 busy clears progress", seq_state, 0);
        rd(K0);
        chk("R9 read under busy ignored", seq_state, 0);
        busy = 1'b0;
        rd(K1);
        chk("R9 no progress kept", seq_state, 0);
    endtask

    task automatic t_late_bus();
        access(1'b0, K0, 2, 13'h1234);
        chk("R10 addr taken while strobe active", seq_state, 1);
        access(1'b0, K1, 1, K2);
        chk("R10 later bus value unused", seq_state, 2);
        rd(K0);
        chk("R10 restart", seq_state, 1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_key();
        t_long_strobe();
        t_wrong_addr();
        t_write_abort();
        t_restart();
        t_busy_idle();
        t_late_bus();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule